// File: doc/BRIEF.md
# Multithreaded Pipeline Thread Selector

This block picks, every clock cycle, which of several hardware thread contexts feeds its next instruction into a scalar in-order pipeline. It drives a registered thread index and a valid strobe. The downstream stages use the index to choose the register set and the program counter. When the strobe is low, the pipeline takes a bubble.

Each thread has a ready flag and two pulses. One pulse reports a long-latency event, such as a cache miss. The other reports that the event has finished. The selector keeps a blocked flag for each thread, set by the event pulse and cleared by the completion pulse. The selector has two modes. In fine-grained mode it moves to a different thread on every cycle where it can, passing over threads that cannot issue. In coarse-grained mode it stays on one thread until that thread stops being eligible, and then moves to the next eligible thread. The mode input may change only while the valid strobe is low.

Top module: `mt_thread_select`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sel_tid` is 0 and `sel_valid` is 0.
- R2: With `mode_blocked` = 0, the registered selection is the first eligible thread found by scanning (last selected + 1), (last selected + 2), and so on modulo the thread count, ending with the last selected thread itself. As a result, the selection changes every cycle whenever two or more threads are eligible.
- R3: Whenever `sel_valid` is 1, `sel_tid` names a thread that was eligible in the cycle before.
- R4: A `lat_event` pulse on a thread sets its blocked flag. A `lat_done` pulse clears the flag. When both pulses arrive in the same cycle, the flag is set. A blocked thread is not selected, even if it is ready, until it has been cleared.
- R5: With `mode_blocked` = 1, if the last selected thread is still eligible, it is selected again.
- R6: With `mode_blocked` = 1, if the last selected thread is not eligible, the selection is the next eligible thread in the same cyclic order as in R2.
- R7: When no thread is eligible, `sel_valid` goes to 0 on the next edge and `sel_tid` keeps its last value.
- R8: A thread is eligible in a cycle when its `thr_ready` bit is 1, its blocked flag is clear, and its `lat_event` bit is 0 in that same cycle. A thread that raises an event therefore cannot be chosen at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_blocked | input | 1 | 0 = switch threads every cycle, 1 = switch only when the current thread cannot issue; change only while `sel_valid` is 0 |
| thr_ready | input | NUM_THREADS | Per-thread flag: the thread has an instruction available |
| lat_event | input | NUM_THREADS | Per-thread pulse: a long-latency event has started |
| lat_done | input | NUM_THREADS | Per-thread pulse: the thread's outstanding event has finished |
| sel_tid | output | TID_W | Registered index of the selected thread |
| sel_valid | output | 1 | Registered strobe: `sel_tid` issues this cycle |

## Verification
The bench builds the selector with three threads. This size is not a power of two, so the modulo wrap in the cyclic scan is exercised as a real subtraction rather than a free bit overflow. With only eight ready patterns and three starting positions, each mode can sweep every pattern from every position. A long pseudo-random run then mixes event and completion pulses. That run covers the corners at small cost: a simultaneous event and completion, an event on the thread whose turn it is, and cycles where every thread is blocked.

// File: rtl/mts_pkg.sv
package mts_pkg;

  localparam int MTS_MAX_THREADS = 32;

  // Cyclic scan: returns the first set bit of elig at base+1, base+2 ...
  // base+n (mod n); returns n when no bit is set.
  function automatic int rr_next(input logic [MTS_MAX_THREADS-1:0] elig,
                                 input int base, input int n);
    int pick;
    int idx;
    pick = n;
    for (int k = MTS_MAX_THREADS; k >= 1; k--) begin
      if (k <= n) begin
        idx = base + k;
        if (idx >= n) idx = idx - n;
        if (elig[idx]) pick = idx;
      end
    end
    return pick;
  endfunction

  // Blocked-flag update: an event wins over a completion in the same cycle.
  function automatic logic blk_update(input logic cur, input logic evt,
                                      input logic done);
    return evt | (cur & ~done);
  endfunction

endpackage

// File: rtl/mts_block_tracker.sv
module mts_block_tracker #(
  parameter int NUM_THREADS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] lat_event,
  input  logic [NUM_THREADS-1:0] lat_done,
  output logic [NUM_THREADS-1:0] blk_q
);
  import mts_pkg::*;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n) blk_q[t] <= 1'b0;
      else        blk_q[t] <= blk_update(blk_q[t], lat_event[t], lat_done[t]);
    end
  end

endmodule

// File: rtl/mts_rr_search.sv
module mts_rr_search #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0] elig,
  input  logic [TID_W-1:0]       base,
  output logic                   found,
  output logic [TID_W-1:0]       pick
);
  import mts_pkg::*;

  logic [MTS_MAX_THREADS-1:0] elig_ext;
  int                         res;

  always_comb begin
    elig_ext                  = '0;
    elig_ext[NUM_THREADS-1:0] = elig;
    res   = rr_next(elig_ext, int'(base), NUM_THREADS);
    found = (res != NUM_THREADS);
    pick  = found ? TID_W'(res) : base;
  end

endmodule

// File: rtl/mt_thread_select.sv
module mt_thread_select #(
  parameter int NUM_THREADS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_blocked,
  input  logic [NUM_THREADS-1:0]  thr_ready,
  input  logic [NUM_THREADS-1:0]  lat_event,
  input  logic [NUM_THREADS-1:0]  lat_done,
  output logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] sel_tid,
  output logic                    sel_valid
);
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

  logic [NUM_THREADS-1:0] blk_q;
  logic [NUM_THREADS-1:0] elig;
  logic                   srch_found;
  logic [TID_W-1:0]       srch_pick;
  logic                   cur_elig;
  logic                   hold_cur;
  logic                   evt_switch;
  logic                   bubble;
  logic [TID_W-1:0]       nxt_tid;

  mts_block_tracker #(.NUM_THREADS(NUM_THREADS)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_event(lat_event),
    .lat_done (lat_done),
    .blk_q    (blk_q)
  );

  assign elig = thr_ready & ~blk_q & ~lat_event;

  mts_rr_search #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_srch (
    .elig (elig),
    .base (sel_tid),
    .found(srch_found),
    .pick (srch_pick)
  );

  // Named events for the checker.
  assign cur_elig   = elig[sel_tid];
  assign hold_cur   = mode_blocked & cur_elig;
  assign evt_switch = mode_blocked & sel_valid & ~cur_elig & srch_found;
  assign bubble     = ~srch_found;
  assign nxt_tid    = hold_cur ? sel_tid : srch_pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_tid   <= '0;
      sel_valid <= 1'b0;
    end else begin
      sel_valid <= ~bubble;
      if (!bubble) sel_tid <= nxt_tid;
    end
  end

endmodule

// File: rtl/mts_checker.sv
module mts_checker #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_blocked,
  input logic [NUM_THREADS-1:0] lat_event,
  input logic [NUM_THREADS-1:0] lat_done,
  input logic [NUM_THREADS-1:0] blk_q,
  input logic [NUM_THREADS-1:0] elig,
  input logic [TID_W-1:0]       sel_tid,
  input logic                   sel_valid
);
  logic [NUM_THREADS-1:0] prev_elig;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_elig <= '0;
    else        prev_elig <= elig;
  end

  AST_SEL_WAS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> prev_elig[sel_tid]); // R3

  AST_BUBBLE_ON_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_elig == '0) |-> !sel_valid); // R7

  AST_COARSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_blocked && sel_valid && elig[sel_tid]) |=>
      (sel_valid && sel_tid == $past(sel_tid))); // R5

  AST_FINE_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_blocked && $countones(elig) > 1) |=>
      (sel_valid && sel_tid != $past(sel_tid))); // R2

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    AST_EVENT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      lat_event[t] |=> blk_q[t]); // R4

    AST_DONE_UNBLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_done[t] && !lat_event[t]) |=> !blk_q[t]); // R4
  end

endmodule

bind mt_thread_select mts_checker #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_blocked(mode_blocked),
  .lat_event   (lat_event),
  .lat_done    (lat_done),
  .blk_q       (blk_q),
  .elig        (elig),
  .sel_tid     (sel_tid),
  .sel_valid   (sel_valid)
);

// File: tb/tb_mt_thread_select.sv
module tb_mt_thread_select;
  localparam int N  = 3;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_blocked = 1'b0;
  logic [N-1:0]  thr_ready = '0;
  logic [N-1:0]  lat_event = '0;
  logic [N-1:0]  lat_done = '0;
  logic [TW-1:0] sel_tid;
  logic          sel_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [N-1:0] m_blk = '0;
  int           m_tid = 0;
  logic [15:0]  lf = 16'hACE1;

  always #5 clk = ~clk;

  mt_thread_select #(.NUM_THREADS(N)) dut (
    .clk(clk), .rst_n(rst_n), .mode_blocked(mode_blocked),
    .thr_ready(thr_ready), .lat_event(lat_event), .lat_done(lat_done),
    .sel_tid(sel_tid), .sel_valid(sel_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (valid*16+tid)", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at a negedge, predict, check after the edge.
  task automatic step(input logic [N-1:0] rdy, input logic [N-1:0] evt,
                      input logic [N-1:0] dn);
    logic [N-1:0] el;
    int pick;
    int cand;
    int exp_tid;
    bit exp_val;
    string tag;
    thr_ready = rdy;
    lat_event = evt;
    lat_done  = dn;
    el   = rdy & ~m_blk & ~evt;
    pick = -1;
    if (mode_blocked && el[m_tid]) pick = m_tid;
    else begin
      for (int k = 1; k <= N; k++) begin
        cand = (m_tid + k) % N;
        if (pick < 0 && el[cand]) pick = cand;
      end
    end
    exp_val = (pick >= 0);
    exp_tid = exp_val ? pick : m_tid;
    if (!exp_val)                  tag = "R7";
    else if (!mode_blocked)        tag = "R2";
    else if (pick == m_tid)        tag = "R5";
    else                           tag = "R6";
    @(posedge clk);
    #1;
    chk(sel_valid == exp_val && int'(sel_tid) == exp_tid, tag,
        int'(sel_valid) * 16 + int'(sel_tid), int'(exp_val) * 16 + exp_tid);
    if (sel_valid)
      chk(el[sel_tid] == 1'b1, "R3 R8", int'(sel_tid), exp_tid);
    for (int t = 0; t < N; t++) m_blk[t] = evt[t] | (m_blk[t] & ~dn[t]);
    m_tid = exp_tid;
    @(negedge clk);
  endtask

  task automatic lf_adv();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic rand_run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      lf_adv();
      step(lf[2:0] | lf[5:3], lf[8:6] & lf[11:9] & lf[14:12], lf[10:8] | lf[13:11]);
    end
  endtask

  task automatic set_mode(input logic m);
    step('0, '0, '1);      // idle cycle: valid drops, all blocks cleared
    mode_blocked = m;      // changes while sel_valid is low
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    chk(sel_valid == 1'b0 && sel_tid == '0, "R1 in reset",
        int'(sel_valid) * 16 + int'(sel_tid), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(sel_valid == 1'b0 && sel_tid == '0, "R1 after reset",
        int'(sel_valid) * 16 + int'(sel_tid), 0);
    @(negedge clk);

    // Fine-grained mode: every ready pattern from every starting position.
    for (int p = 0; p < (1 << N); p++)
      for (int r = 0; r < 2 * N; r++) step(N'(p), '0, '0);
    rand_run(400);

    // R8: event on the thread whose turn is next is skipped at that edge.
    set_mode(1'b0);
    step('1, '0, '0);
    t = (m_tid + 1) % N;
    step('1, N'(1 << t), '0);
    chk(int'(sel_tid) != t, "R8", int'(sel_tid), (t + 1) % N);

    // R4: blocked thread stays out while ready; event beats completion.
    for (int r = 0; r < 4; r++) begin
      step('1, '0, '0);
      chk(int'(sel_tid) != t, "R4 blocked", int'(sel_tid), -1);
    end
    step('1, N'(1 << t), N'(1 << t));
    step(N'(1 << t), '0, '0);
    chk(sel_valid == 1'b0, "R4 event wins", int'(sel_valid), 0);
    step(N'(1 << t), '0, N'(1 << t));
    step(N'(1 << t), '0, '0);
    chk(sel_valid == 1'b1 && int'(sel_tid) == t, "R4 released",
        int'(sel_valid) * 16 + int'(sel_tid), 16 + t);

    // Coarse-grained mode.
    set_mode(1'b1);
    for (int p = 0; p < (1 << N); p++)
      for (int r = 0; r < 2 * N; r++) step(N'(p), '0, '0);
    step('1, '0, '0);
    t = m_tid;
    for (int r = 0; r < 5; r++) step('1, '0, '0);
    chk(int'(sel_tid) == t, "R5 stays", int'(sel_tid), t);
    step('1, N'(1 << t), '0);
    chk(int'(sel_tid) == (t + 1) % N, "R6 switch on event", int'(sel_tid), (t + 1) % N);
    rand_run(400);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule